// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Sequencer

This block sits next to the program counter of an instruction fetch unit and repeats a region of code a fixed number of times. Software never has to keep a loop counter or run a branch at the bottom of the loop. One setup command gives the block three values: the first address of the region, the last address of the region and a trip count.

The trip count comes from a general register and is held in a dedicated counter inside the block. From then on the block compares every valid fetch address with the stored last address. When the two match and more than one pass remains, the block does two things in the same cycle. It forces the next fetch address to the first address of the region, and it decrements the counter. When the last pass reaches the end address, fetch continues to the next sequential instruction and the loop shuts itself off.

Because the loop-back is chosen in the same cycle as the fetch of the last instruction, the return to the top of the loop costs no cycles and causes no misprediction bubble. The loop body may be a single instruction, whose address is both the first and the last address. The active flag and the remaining count are brought out as outputs for test and debug.

Top module: `hwloop_seq`

## Requirements
- R1: While reset is high, and on the cycle after reset is released, `loop_active` is 0, `loop_count` is 0 and `redirect` is 0.
- R2: A setup (`setup_valid`=1) with a nonzero count sets `loop_active` to 1 and `loop_count` to the supplied count on the next cycle, and stores the supplied start and end addresses.
- R3: A setup with count 0 leaves `loop_active`=0 and `loop_count`=0. A later fetch of the end address then gives `redirect`=0 and `next_pc` = fetch address + STEP, so the body runs once as straight-line code.
- R4: When the loop is active, `fetch_valid`=1, the fetch address equals the stored end address and `loop_count` > 1, then in that same cycle `redirect`=1 and `next_pc` equals the stored start address. On the next cycle `loop_count` is one lower.
- R5: When the loop is active, `fetch_valid`=1, the fetch address equals the end address and `loop_count`=1, then `redirect`=0 and `next_pc` = end address + STEP in that cycle. On the next cycle `loop_active`=0 and `loop_count`=0.
- R6: A valid fetch at any address other than the end address gives `next_pc` = fetch address + STEP and `redirect`=0, and leaves `loop_count` and `loop_active` unchanged.
- R7: With start equal to end (a one-instruction body) and count N ≥ 1, repeatedly fetching the address that `next_pc` gives runs that instruction exactly N times, and then fetch moves on to address + STEP.
- R8: A setup arriving while a loop is active replaces start, end and count on the next cycle. If the fetch in the same cycle hits the old end address, the loop-back for that cycle still uses the old start address, and the counter takes the new count instead of decrementing.
- R9: When `fetch_valid`=0, `redirect` is 0 and the counter does not change, even if `fetch_pc` equals the end address.
- R10: The default STEP is 4 bytes. `next_pc` is `fetch_pc` + STEP whenever `redirect` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| setup_valid | input | 1 | Loads a new loop configuration |
| setup_start | input | AW | First address of the loop body |
| setup_end | input | AW | Last address of the loop body |
| setup_count | input | CW | Number of passes through the body |
| fetch_valid | input | 1 | The fetch address this cycle is real |
| fetch_pc | input | AW | Address being fetched this cycle |
| next_pc | output | AW | Address to fetch next cycle |
| redirect | output | 1 | Loop-back taken this cycle |
| loop_active | output | 1 | A loop is armed |
| loop_count | output | CW | Passes remaining, including the current one |

## Verification
The checker watches several rules on every cycle. A setup must load the counter exactly, and an idle loop must carry a zero count. Every loop-back must lower the count by one, and a loop may only go inactive from a count of one. No redirect may occur without a valid fetch, and any other cycle must hold the count. Whether `next_pc` points at the right start address, how many times a single-instruction body runs, and how a setup that collides with an end-address hit is ordered can only be shown by the bench. It does this by walking a fetch stream that follows `next_pc` and comparing against its own model of the loop.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

    // Operation applied to the trip counter in one cycle.
    typedef enum logic [1:0] {
        CNT_HOLD  = 2'd0,
        CNT_LOAD  = 2'd1,
        CNT_DEC   = 2'd2,
        CNT_CLEAR = 2'd3
    } cnt_op_e;

    // Source of the next fetch address.
    typedef enum logic {
        NPC_SEQ  = 1'b0,
        NPC_LOOP = 1'b1
    } npc_src_e;

    // Decision bundle produced by the address compare.
    typedef struct packed {
        logic     hit;      // valid fetch of the end address while armed
        logic     last;     // the hit is on the final pass
        npc_src_e src;      // where the next fetch comes from
    } match_t;

    // Select the counter operation; setup outranks the end-address hit.
    function automatic cnt_op_e pick_cnt_op(input logic setup, input match_t m);
        if (setup)
            return CNT_LOAD;
        else if (m.hit && m.last)
            return CNT_CLEAR;
        else if (m.hit)
            return CNT_DEC;
        return CNT_HOLD;
    endfunction

endpackage

// File: rtl/hwloop_cfg.sv
module hwloop_cfg #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] start_in,
    input  logic [AW-1:0] end_in,
    output logic [AW-1:0] start_q,
    output logic [AW-1:0] end_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            end_q   <= '0;
        end else if (load) begin
            start_q <= start_in;
            end_q   <= end_in;
        end
    end

endmodule

// File: rtl/hwloop_cnt.sv
module hwloop_cnt
    import hwloop_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  cnt_op_e       op,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] count_q,
    output logic          active_q
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] count_d;
    logic          active_d;

    always_comb begin
        count_d  = count_q;
        active_d = active_q;
        unique case (op)
            CNT_LOAD: begin
                count_d  = load_val;
                active_d = (load_val != '0);
            end
            CNT_DEC: begin
                count_d  = count_q - ONE;
            end
            CNT_CLEAR: begin
                count_d  = '0;
                active_d = 1'b0;
            end
            default: begin
                count_d  = count_q;
                active_d = active_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            active_q <= 1'b0;
        end else begin
            count_q  <= count_d;
            active_q <= active_d;
        end
    end

endmodule

// File: rtl/hwloop_match.sv
module hwloop_match
    import hwloop_pkg::*;
#(
    parameter int AW   = 32,
    parameter int CW   = 16,
    parameter int STEP = 4
) (
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_pc,
    input  logic          active,
    input  logic [CW-1:0] count,
    input  logic [AW-1:0] start_addr,
    input  logic [AW-1:0] end_addr,
    output match_t        m,
    output logic [AW-1:0] next_pc
);

    localparam logic [AW-1:0] STEP_V = AW'(STEP);
    localparam logic [CW-1:0] ONE    = CW'(1);

    logic [AW-1:0] seq_pc;

    // The sequential address is formed in parallel with the compare so
    // the loop-back only adds one mux level on the fetch path.
    assign seq_pc = fetch_pc + STEP_V;

    always_comb begin
        m.hit  = fetch_valid && active && (fetch_pc == end_addr);
        m.last = (count == ONE);
        m.src  = (m.hit && !m.last) ? NPC_LOOP : NPC_SEQ;
    end

    assign next_pc = (m.src == NPC_LOOP) ? start_addr : seq_pc;

endmodule

// File: rtl/hwloop_seq.sv
module hwloop_seq
    import hwloop_pkg::*;
#(
    parameter int AW   = 32,
    parameter int CW   = 16,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          setup_valid,
    input  logic [AW-1:0] setup_start,
    input  logic [AW-1:0] setup_end,
    input  logic [CW-1:0] setup_count,
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_pc,
    output logic [AW-1:0] next_pc,
    output logic          redirect,
    output logic          loop_active,
    output logic [CW-1:0] loop_count
);

    logic [AW-1:0] start_q;
    logic [AW-1:0] end_q;
    match_t        m;
    cnt_op_e       op;

    hwloop_cfg #(.AW(AW)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .load     (setup_valid),
        .start_in (setup_start),
        .end_in   (setup_end),
        .start_q  (start_q),
        .end_q    (end_q)
    );

    hwloop_match #(.AW(AW), .CW(CW), .STEP(STEP)) u_match (
        .fetch_valid (fetch_valid),
        .fetch_pc    (fetch_pc),
        .active      (loop_active),
        .count       (loop_count),
        .start_addr  (start_q),
        .end_addr    (end_q),
        .m           (m),
        .next_pc     (next_pc)
    );

    assign op = pick_cnt_op(setup_valid, m);

    hwloop_cnt #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .load_val (setup_count),
        .count_q  (loop_count),
        .active_q (loop_active)
    );

    assign redirect = (m.src == NPC_LOOP);

endmodule

// File: rtl/hwloop_seq_chk.sv
module hwloop_seq_chk #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          setup_valid,
    input logic [CW-1:0] setup_count,
    input logic          fetch_valid,
    input logic          redirect,
    input logic          loop_active,
    input logic [CW-1:0] loop_count
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!loop_active && loop_count == '0));

    assert_setup_loads_R2: assert property (@(posedge clk) disable iff (rst)
        setup_valid |=> (loop_count == $past(setup_count)) &&
                        (loop_active == ($past(setup_count) != '0)));

    assert_idle_zero_R3: assert property (@(posedge clk) disable iff (rst)
        !loop_active |-> (loop_count == '0) && !redirect);

    assert_redirect_dec_R4: assert property (@(posedge clk) disable iff (rst)
        (redirect && !setup_valid) |=>
            loop_active && (loop_count == $past(loop_count) - CW'(1)));

    assert_exit_from_one_R5: assert property (@(posedge clk) disable iff (rst)
        ($fell(loop_active) && !$past(setup_valid)) |-> ($past(loop_count) == CW'(1)));

    assert_hold_count_R6: assert property (@(posedge clk) disable iff (rst)
        (!setup_valid && !redirect) |=>
            (loop_count == $past(loop_count)) || (loop_count == '0));

    assert_needs_fetch_R9: assert property (@(posedge clk) disable iff (rst)
        redirect |-> fetch_valid);

endmodule

bind hwloop_seq hwloop_seq_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .setup_valid (setup_valid),
    .setup_count (setup_count),
    .fetch_valid (fetch_valid),
    .redirect    (redirect),
    .loop_active (loop_active),
    .loop_count  (loop_count)
);

// File: tb/tb_hwloop_seq.sv
`timescale 1ns/1ps
module tb_hwloop_seq;

    localparam int AW   = 32;
    localparam int CW   = 16;
    localparam int STEP = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          setup_valid = 1'b0;
    logic [AW-1:0] setup_start = '0;
    logic [AW-1:0] setup_end   = '0;
    logic [CW-1:0] setup_count = '0;
    logic          fetch_valid = 1'b0;
    logic [AW-1:0] fetch_pc    = '0;
    logic [AW-1:0] next_pc;
    logic          redirect;
    logic          loop_active;
    logic [CW-1:0] loop_count;

    always #2.5 clk = ~clk;

    hwloop_seq #(.AW(AW), .CW(CW), .STEP(STEP)) dut (
        .clk(clk), .rst(rst),
        .setup_valid(setup_valid), .setup_start(setup_start),
        .setup_end(setup_end), .setup_count(setup_count),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .next_pc(next_pc), .redirect(redirect),
        .loop_active(loop_active), .loop_count(loop_count)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Bench model of the loop state.
    logic [AW-1:0] m_start = '0, m_end = '0;
    logic [CW-1:0] m_cnt = '0;
    logic          m_act = 1'b0;
    logic [AW-1:0] e_npc;
    logic          e_red;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic model_hit(input logic fv, input logic [AW-1:0] pc);
        return fv && m_act && (pc == m_end);
    endfunction

    // One clock: drive inputs, check the same-cycle outputs, then the
    // registered state after the edge.
    task automatic cyc(input logic sv, input logic [AW-1:0] ss, input logic [AW-1:0] se,
                       input logic [CW-1:0] sc, input logic fv, input logic [AW-1:0] pc,
                       input string req);
        logic hit;
        @(negedge clk);
        setup_valid = sv; setup_start = ss; setup_end = se; setup_count = sc;
        fetch_valid = fv; fetch_pc = pc;
        #1;
        hit   = model_hit(fv, pc);
        e_red = hit && (m_cnt > 1);
        e_npc = e_red ? m_start : pc + AW'(STEP);
        chk(req, "redirect", {63'd0, redirect}, {63'd0, e_red});
        chk(req, "next_pc", {32'd0, next_pc}, {32'd0, e_npc});
        @(posedge clk);
        if (sv) begin
            m_start = ss; m_end = se; m_cnt = sc; m_act = (sc != 0);
        end else if (hit) begin
            if (m_cnt > 1) m_cnt = m_cnt - 1;
            else begin m_cnt = '0; m_act = 1'b0; end
        end
        #1;
        chk(req, "loop_active", {63'd0, loop_active}, {63'd0, m_act});
        chk(req, "loop_count", {48'd0, loop_count}, {48'd0, m_cnt});
    endtask

    task automatic fetch(input logic [AW-1:0] pc, input string req);
        cyc(1'b0, '0, '0, '0, 1'b1, pc, req);
    endtask

    task automatic setup(input logic [AW-1:0] s, input logic [AW-1:0] e,
                         input logic [CW-1:0] c, input string req);
        cyc(1'b1, s, e, c, 1'b0, '0, req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 190000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [AW-1:0] pc;
        int runs;
        void'($urandom(32'h5eed_1234));

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1", "loop_active", {63'd0, loop_active}, 64'd0);
        chk("R1", "loop_count", {48'd0, loop_count}, 64'd0);
        chk("R1", "redirect", {63'd0, redirect}, 64'd0);

        // R10: inactive fetch just steps by 4
        fetch(32'h200, "R10");
        chk("R10", "step", {32'd0, e_npc}, 64'h204);

        // R3: count zero leaves the loop off; body runs straight through
        setup(32'h300, 32'h308, 16'd0, "R3");
        fetch(32'h300, "R3"); fetch(32'h304, "R3"); fetch(32'h308, "R3");
        chk("R3", "fallthrough", {32'd0, next_pc}, 64'h30c);

        // R2, R4, R6: three-pass loop over three instructions
        setup(32'h400, 32'h408, 16'd3, "R2");
        chk("R2", "count_loaded", {48'd0, loop_count}, 64'd3);
        fetch(32'h400, "R6"); fetch(32'h404, "R6");
        fetch(32'h408, "R4");
        chk("R4", "loop_back", {32'd0, e_npc}, 64'h400);
        fetch(32'h400, "R6"); fetch(32'h404, "R6"); fetch(32'h408, "R4");
        fetch(32'h400, "R6"); fetch(32'h404, "R6");
        // R5: final pass falls through and disarms
        fetch(32'h408, "R5");
        chk("R5", "exit_pc", {32'd0, e_npc}, 64'h40c);
        chk("R5", "inactive", {63'd0, loop_active}, 64'd0);

        // R9: end address presented without fetch_valid
        setup(32'h500, 32'h504, 16'd2, "R9");
        cyc(1'b0, '0, '0, '0, 1'b0, 32'h504, "R9");
        chk("R9", "count_held", {48'd0, loop_count}, 64'd2);

        // R8: setup collides with an end hit; old start used, new count wins
        cyc(1'b1, 32'h600, 32'h610, 16'd7, 1'b1, 32'h504, "R8");
        chk("R8", "old_start", {32'd0, e_npc}, 64'h500);
        chk("R8", "new_count", {48'd0, loop_count}, 64'd7);
        fetch(32'h504, "R8");
        chk("R8", "old_end_ignored", {63'd0, redirect}, 64'd0);
        fetch(32'h610, "R8");
        chk("R8", "new_start", {32'd0, next_pc}, 64'h600);

        // R7: one-instruction body, count 5
        setup(32'h700, 32'h700, 16'd5, "R7");
        pc = 32'h700; runs = 0;
        for (int i = 0; i < 12 && pc == 32'h700; i++) begin
            fetch(pc, "R7");
            runs++;
            pc = e_npc;
        end
        chk("R7", "executions", runs, 64'd5);
        chk("R7", "after", {32'd0, pc}, 64'h704);

        // Random walk through small loops, following next_pc.
        pc = 32'h1000;
        for (int i = 0; i < 4000; i++) begin
            logic sv, fv;
            logic [AW-1:0] s, e;
            logic [CW-1:0] c;
            sv = ($urandom % 20) == 0;
            fv = ($urandom % 6) != 0;
            s  = 32'h1000 + 4 * ($urandom % 12);
            e  = s + 4 * ($urandom % 4);
            c  = CW'($urandom % 6);
            cyc(sv, s, e, c, fv, pc, "R6");
            if (fv) pc = e_npc;
            if (($urandom % 40) == 0 || pc > 32'h1060) pc = 32'h1000 + 4 * ($urandom % 12);
        end

        finish_run();
    end

endmodule